// File: doc/BRIEF.md
# Watchdog Timer Start/Stop Controller

This block is a free-running watchdog counter with its start and stop control. A 15-bit counter is preset from a 7-bit software-written reload value, which fills its upper bits. When the counter rolls over, the block emits a one-cycle watchdog reset pulse. Software must keep the counter from rolling over by refreshing it.

The counter can be started in two ways. The first is a board strap level, which the block captures while the external reset or the hardware power-down input is asserted. The second is a software start bit. Once the counter is running, only a small set of events can stop it.

When the strap selects the hardware start, the block also reports that the power-saving modes are not permitted and ignores idle and power-down requests. A level change on the strap during normal operation has no effect, because the strap is only looked at while one of the two hold inputs is active.

Top module: `wdog_ctrl`

## Requirements
- R1: The 7-bit reload value reads as 0 after an external reset, after a hardware power-down, and after every watchdog reset pulse. `rel_we` loads it from `rel_wdata` at any time, including while the counter is running.
- R2: A load presets the counter to the reload value R followed by 8 zero bits. `wd_reset` is then high in the cycle after the (32768 − 256·R)-th rising edge that follows the loading edge, counting the loading edge itself as edge 0.
- R3: If `strap_start` is 1 while `ext_rst` or `hw_pd` is asserted, the counter loads and `running` goes to 1 at the first clock edge after both are released. It runs with the default period (R = 0).
- R4: A rising edge on `strap_start` while neither `ext_rst` nor `hw_pd` is asserted never starts the counter.
- R5: `ps_allow` equals the inverse of the strap level captured during the last hold. While `ps_allow` is 0, `idle_req` and `pdown_req` are ignored and the counter keeps running.
- R6: A cycle with `start_we`=1 and `start_wdata`=1 while the counter is stopped starts it, loading from the reload value present at that moment.
- R7: While the counter is running, any `start_we` write (data 0 or 1) has no effect: the counter is neither stopped nor reloaded.
- R8: `ext_rst` forces `running` to 0. If `strap_start` is 0 during that reset, the counter stays stopped after release.
- R9: `hw_pd` forces `running` to 0 whatever the strap level.
- R10: While `ps_allow` is 1, a cycle with `idle_req` or `pdown_req` high stops the counter. No pulse follows while it is stopped.
- R11: `refresh` while running presets the counter from the current reload value, which restarts the full period.
- R12: Rollover gives a `wd_reset` pulse exactly one cycle wide. After the pulse the counter keeps running with the default period and sets `wd_flag`. `wd_flag` stays at 1 until `ext_rst` or `hw_pd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| ext_rst | input | 1 | External hardware reset, synchronous, active high |
| hw_pd | input | 1 | Hardware power-down, synchronous, active high |
| strap_start | input | 1 | Strap level that selects the hardware start |
| rel_we | input | 1 | Write strobe for the reload value |
| rel_wdata | input | 7 | Reload value to write |
| start_we | input | 1 | Write strobe for the software start bit |
| start_wdata | input | 1 | Software start bit value |
| idle_req | input | 1 | Idle mode entry request |
| pdown_req | input | 1 | Software power-down entry request |
| refresh | input | 1 | Counter refresh strobe |
| wd_reset | output | 1 | One-cycle watchdog reset pulse |
| ps_allow | output | 1 | Power-saving modes permitted |
| running | output | 1 | Counter running status |
| wd_flag | output | 1 | Sticky flag: a watchdog reset has occurred |

## Verification
The hardest situation to reach is the clearing of the reload value by a hold. It can only be seen through the period of the next run.

To observe it, the stimulus programs a short period and starts the counter by software. It then raises the strap and asserts hardware power-down while the counter is running, and releases power-down so that the hardware start fires. The scoreboard expects the full default period on that run. A rising edge on the strap at run time, and a stop request while the strap is captured, are both driven while the same scoreboard watches for pulses that should not appear.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int unsigned WD_CNT_W_DEF = 15;
  localparam int unsigned WD_REL_W_DEF = 7;
endpackage

// File: rtl/wdog_reload.sv
module wdog_reload #(
  parameter int unsigned REL_W = wdog_pkg::WD_REL_W_DEF
) (
  input  logic             clk,
  input  logic             hold,
  input  logic             wd_pulse,
  input  logic             we,
  input  logic [REL_W-1:0] wdata,
  output logic [REL_W-1:0] rel_q
);
  always_ff @(posedge clk) begin
    if (hold || wd_pulse) rel_q <= '0;
    else if (we)          rel_q <= wdata;
  end

  // R1: any hold or watchdog pulse leaves the reload value at zero
  a_r1_reload_cleared: assert property (@(posedge clk)
    (hold || wd_pulse) |=> (rel_q == '0));
endmodule

// File: rtl/wdog_start_ctl.sv
module wdog_start_ctl (
  input  logic clk,
  input  logic hold,
  input  logic strap,
  input  logic start_we,
  input  logic start_wdata,
  input  logic idle_req,
  input  logic pdown_req,
  output logic run,
  output logic ps_allow,
  output logic load
);
  logic arm_q;
  logic stop_req;
  logic sw_go;

  assign stop_req = ps_allow && (idle_req || pdown_req);
  assign sw_go    = start_we && start_wdata && !run;
  assign load     = !hold && !stop_req && (arm_q || sw_go);

  always_ff @(posedge clk) begin
    if (hold) begin
      run      <= 1'b0;
      arm_q    <= strap;
      ps_allow <= !strap;
    end else begin
      arm_q <= 1'b0;
      if (stop_req)  run <= 1'b0;
      else if (load) run <= 1'b1;
    end
  end

  // R4: outside a hold, only a pending strap capture or a software start can start
  a_r4_no_runtime_strap: assert property (@(posedge clk) disable iff (hold)
    (!run && !arm_q && !(start_we && start_wdata)) |=> !run);

  // R5: a strapped start cannot be stopped by power-save requests
  a_r5_strap_locks_run: assert property (@(posedge clk) disable iff (hold)
    (!ps_allow && run) |=> run);

  // R5: permission only changes during a hold
  a_r5_ps_stable: assert property (@(posedge clk) disable iff (hold)
    !$past(hold) |-> $stable(ps_allow));

  // R10: permitted idle/power-down entry stops the counter
  a_r10_request_stops: assert property (@(posedge clk) disable iff (hold)
    (ps_allow && run && (idle_req || pdown_req)) |=> !run);

  // R8/R9: a hold stops the counter
  a_r8_hold_stops: assert property (@(posedge clk)
    hold |=> !run);
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int unsigned CNT_W = wdog_pkg::WD_CNT_W_DEF,
  parameter int unsigned REL_W = wdog_pkg::WD_REL_W_DEF
) (
  input  logic             clk,
  input  logic             hold,
  input  logic             load,
  input  logic             refresh,
  input  logic             run,
  input  logic [REL_W-1:0] rel,
  output logic             wd_pulse,
  output logic             wd_flag
);
  localparam int unsigned LOW_W = CNT_W - REL_W;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] load_val;

  assign load_val = {rel, {LOW_W{1'b0}}};

  always_ff @(posedge clk) begin
    if (hold) begin
      cnt_q    <= '0;
      wd_pulse <= 1'b0;
      wd_flag  <= 1'b0;
    end else begin
      wd_pulse <= 1'b0;
      if (load || (run && refresh)) begin
        cnt_q <= load_val;
      end else if (run) begin
        if (&cnt_q) begin
          cnt_q    <= '0;
          wd_pulse <= 1'b1;
          wd_flag  <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  // R12: the pulse lasts exactly one cycle
  a_r12_pulse_single: assert property (@(posedge clk) disable iff (hold)
    wd_pulse |=> !wd_pulse);

  // R12: the flag is sticky between holds
  a_r12_flag_sticky: assert property (@(posedge clk) disable iff (hold)
    wd_flag |=> wd_flag);

  // R10: a stopped counter holds its value
  a_r10_stopped_holds: assert property (@(posedge clk) disable iff (hold)
    (!run && !load) |=> $stable(cnt_q));

  // R11: refresh presets from the reload value
  a_r11_refresh_loads: assert property (@(posedge clk) disable iff (hold)
    (run && refresh) |=> (cnt_q == $past(load_val)));
endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl #(
  parameter int unsigned CNT_W = wdog_pkg::WD_CNT_W_DEF,
  parameter int unsigned REL_W = wdog_pkg::WD_REL_W_DEF
) (
  input  logic             clk,
  input  logic             ext_rst,
  input  logic             hw_pd,
  input  logic             strap_start,
  input  logic             rel_we,
  input  logic [REL_W-1:0] rel_wdata,
  input  logic             start_we,
  input  logic             start_wdata,
  input  logic             idle_req,
  input  logic             pdown_req,
  input  logic             refresh,
  output logic             wd_reset,
  output logic             ps_allow,
  output logic             running,
  output logic             wd_flag
);
  logic             hold;
  logic             load;
  logic             pulse;
  logic [REL_W-1:0] rel_q;

  assign hold     = ext_rst || hw_pd;
  assign wd_reset = pulse;

  wdog_reload #(.REL_W(REL_W)) reload_i (
    .clk(clk), .hold(hold), .wd_pulse(pulse),
    .we(rel_we), .wdata(rel_wdata), .rel_q(rel_q)
  );

  wdog_start_ctl start_i (
    .clk(clk), .hold(hold), .strap(strap_start),
    .start_we(start_we), .start_wdata(start_wdata),
    .idle_req(idle_req), .pdown_req(pdown_req),
    .run(running), .ps_allow(ps_allow), .load(load)
  );

  wdog_counter #(.CNT_W(CNT_W), .REL_W(REL_W)) count_i (
    .clk(clk), .hold(hold), .load(load), .refresh(refresh),
    .run(running), .rel(rel_q), .wd_pulse(pulse), .wd_flag(wd_flag)
  );
endmodule

// File: tb/wdog_ctrl_tb_top.sv
module wdog_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int REL_W = 7;

  logic clk = 1'b0;
  logic ext_rst = 1'b1, hw_pd = 1'b0, strap_start = 1'b0;
  logic rel_we = 1'b0, start_we = 1'b0, start_wdata = 1'b0;
  logic [REL_W-1:0] rel_wdata = '0;
  logic idle_req = 1'b0, pdown_req = 1'b0, refresh = 1'b0;
  logic wd_reset, ps_allow, running, wd_flag;

  int cyc = 0, mark = 0, pulses = 0;
  int n_chk = 0, n_fail = 0;
  int exp_q[$];
  logic prev_pulse = 1'b0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc = cyc + 1;

  wdog_ctrl dut_i (
    .clk(clk), .ext_rst(ext_rst), .hw_pd(hw_pd), .strap_start(strap_start),
    .rel_we(rel_we), .rel_wdata(rel_wdata), .start_we(start_we),
    .start_wdata(start_wdata), .idle_req(idle_req), .pdown_req(pdown_req),
    .refresh(refresh), .wd_reset(wd_reset), .ps_allow(ps_allow),
    .running(running), .wd_flag(wd_flag)
  );

  function automatic int period(input int r);
    return 32768 - 256 * r;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // Monitor: pops expected periods as pulses appear
  always @(negedge clk) begin
    if (wd_reset) begin
      pulses++;
      if (exp_q.size() == 0) chk(0, "R10/R12 unexpected pulse", cyc - mark, -1);
      else begin
        int e;
        e = exp_q.pop_front();
        chk((cyc - mark) == e, "R2 pulse timing", cyc - mark, e);
      end
      mark = cyc;
    end
    if (wd_reset && prev_pulse) chk(0, "R12 pulse width", 2, 1);
    prev_pulse = wd_reset;
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_rel(input int v);
    @(negedge clk); rel_we = 1'b1; rel_wdata = REL_W'(v);
    @(negedge clk); rel_we = 1'b0;
  endtask

  task automatic sw_start(input bit d, input bit set_mark);
    @(negedge clk); start_we = 1'b1; start_wdata = d;
    if (set_mark) mark = cyc + 1;
    @(negedge clk); start_we = 1'b0; start_wdata = 1'b0;
  endtask

  task automatic wait_pulse(input int k);
    while (pulses < k) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog expired", cyc, 0);
    finish_run();
  end

  initial begin
    step(5);
    chk(running == 1'b0, "R8 reset running", int'(running), 0);
    chk(ps_allow == 1'b1, "R5 reset ps_allow", int'(ps_allow), 1);
    chk(wd_reset == 1'b0, "R12 reset pulse", int'(wd_reset), 0);
    chk(wd_flag == 1'b0, "R12 reset flag", int'(wd_flag), 0);
    ext_rst = 1'b0;
    step(2);

    // R4: run-time strap edge
    strap_start = 1'b1;
    step(20);
    chk(running == 1'b0, "R4 strap edge no start", int'(running), 0);
    chk(ps_allow == 1'b1, "R4 ps_allow unchanged", int'(ps_allow), 1);
    strap_start = 1'b0;

    // R6 software start, R7 writes while running ignored
    write_rel(127);
    exp_q.push_back(period(127));
    sw_start(1'b1, 1'b1);
    chk(running == 1'b1, "R6 software start", int'(running), 1);
    step(50);
    sw_start(1'b0, 1'b0);
    chk(running == 1'b1, "R7 start=0 ignored", int'(running), 1);
    sw_start(1'b1, 1'b0);
    exp_q.push_back(period(0)); // R1: cleared after watchdog pulse
    wait_pulse(1);
    step(1);
    chk(wd_flag == 1'b1, "R12 flag set", int'(wd_flag), 1);
    chk(running == 1'b1, "R12 keeps running", int'(running), 1);
    wait_pulse(2);

    // R11 refresh with a value written while running (R1)
    write_rel(126);
    @(negedge clk); refresh = 1'b1;
    @(negedge clk); refresh = 1'b0;
    step(300);
    exp_q.push_back(period(126));
    @(negedge clk); refresh = 1'b1; mark = cyc + 1;
    @(negedge clk); refresh = 1'b0;
    wait_pulse(3);

    // R10 permitted requests stop
    step(2);
    @(negedge clk); idle_req = 1'b1;
    @(negedge clk); idle_req = 1'b0;
    chk(running == 1'b0, "R10 idle stops", int'(running), 0);
    step(600);
    chk(pulses == 3, "R10 no pulse while stopped", pulses, 3);
    sw_start(1'b1, 1'b0);
    @(negedge clk); pdown_req = 1'b1;
    @(negedge clk); pdown_req = 1'b0;
    chk(running == 1'b0, "R10 pdown stops", int'(running), 0);

    // R8 external reset with strap low
    sw_start(1'b1, 1'b0);
    step(5);
    ext_rst = 1'b1;
    step(3);
    chk(running == 1'b0, "R8 reset stops", int'(running), 0);
    chk(wd_flag == 1'b0, "R12 flag cleared by reset", int'(wd_flag), 0);
    ext_rst = 1'b0;
    step(50);
    chk(running == 1'b0, "R8 stays stopped", int'(running), 0);
    chk(pulses == 3, "R8 no pulse", pulses, 3);

    // R9 power-down stop, R3 hardware start, R1 clear, R5 lock
    write_rel(127);
    sw_start(1'b1, 1'b0);
    step(5);
    strap_start = 1'b1;
    hw_pd = 1'b1;
    step(3);
    chk(running == 1'b0, "R9 power-down stops", int'(running), 0);
    chk(ps_allow == 1'b0, "R5 strap blocks power save", int'(ps_allow), 0);
    exp_q.push_back(period(0));
    @(negedge clk); hw_pd = 1'b0; mark = cyc + 1;
    @(negedge clk);
    chk(running == 1'b1, "R3 hardware start", int'(running), 1);
    strap_start = 1'b0;
    step(5);
    @(negedge clk); idle_req = 1'b1; pdown_req = 1'b1;
    @(negedge clk); idle_req = 1'b0; pdown_req = 1'b0;
    chk(running == 1'b1, "R5 requests ignored", int'(running), 1);
    chk(ps_allow == 1'b0, "R5 ps_allow held", int'(ps_allow), 0);
    wait_pulse(4);
    step(1);
    chk(wd_flag == 1'b1, "R12 flag after hw run", int'(wd_flag), 1);
    chk(exp_q.size() == 0, "R2 all pulses seen", exp_q.size(), 0);
    finish_run();
  end
endmodule